// File: doc/BRIEF.md
# Bipolar Line Encoder with Three-Zero Substitution

The block takes one NRZ bit per line-clock cycle and turns it into a pair of pulse rails for a line interface unit. A mark is sent as a pulse on the positive or the negative rail, and a space is sent as no pulse. In alternate-mark mode, the polarity flips on every mark. In substitution mode, every run of three spaces is replaced by a short code that holds a deliberate polarity violation. This keeps pulses on the line during long space runs. A unipolar mode bypasses all bipolar coding.

The encoder holds the incoming stream in a short lookahead window. A run of spaces is therefore recognised before its first space leaves the block, so the whole run can be rewritten. The rewrite is either "space, space, V" or "B, space, V". B is a pulse that obeys the alternation rule and V is a pulse that repeats the previous polarity. The choice keeps the number of alternation-obeying pulses between two violations odd. A further control makes the rails change on either the rising or the falling edge of the line clock, which eases setup and hold at the receiving device.

Top module: `b3zs_line_enc`

## Requirements
- R1: In bipolar mode with `code_ami`=1, each mark gives one pulse whose polarity is opposite to the previous pulse, and each space gives no pulse. The first pulse after reset is on the positive rail.
- R2: In bipolar mode with `code_ami`=0, every run of three spaces is replaced as one group. If an odd number of alternation-obeying pulses has been sent since the last violation (or since reset), the group is space, space, V. If that number is even, the group is B, space, V.
- R3: A V pulse has the same polarity as the pulse sent just before it. The count of alternation-obeying pulses restarts at zero after each V.
- R4: `code_ami` selects the line code: 0 selects three-zero substitution and 1 selects plain alternate-mark coding. With value 1, space runs of any length produce no pulses.
- R5: With `unipolar`=1, `pos_o` carries the data bit unchanged, `neg_o` stays low, and `code_ami` has no effect.
- R6: A bit sampled on rising edge n appears on the rails just after rising edge n+2 when `fall_edge`=0. The latency is the same in every mode.
- R7: With `fall_edge`=1, the rails keep their value across rising edge n+2 and take the value for bit n at the following falling edge.
- R8: While `rst` is high, both rails are low. After reset, the polarity state is negative and the pulse count is zero.
- R9: `pos_o` and `neg_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit line clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial NRZ data, one bit per cycle |
| code_ami | input | 1 | Line code select: 0 = three-zero substitution, 1 = alternate mark |
| unipolar | input | 1 | 1 = send data unipolar on `pos_o` |
| fall_edge | input | 1 | 1 = rails change on the falling clock edge |
| pos_o | output | 1 | Positive pulse rail |
| neg_o | output | 1 | Negative pulse rail |

## Verification
The hardest case to reach is the space, space, V form of the substitution. It needs an odd pulse count at the moment a three-space run enters the window. That count depends on every mark sent since the last violation, so the stimulus has to interleave mark groups of odd and even length with space runs. The bench streams such mixed patterns, together with long space runs that chain several substitutions back to back, through a bit-accurate reference model. That model decides each group with full knowledge of the following bits.

// File: rtl/b3zs_pkg.sv
package b3zs_pkg;

    // Symbols held in the lookahead window
    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,   // raw zero, still eligible for substitution
        SYM_MARK  = 2'd1,   // raw one
        SYM_FILL  = 2'd2,   // zero already claimed by a substitution
        SYM_VIOL  = 2'd3    // violation pulse planted by a substitution
    } sym_e;

    typedef struct packed {
        logic p;
        logic n;
    } rails_t;

    localparam rails_t RAILS_IDLE = '{p: 1'b0, n: 1'b0};

    // Default run length that triggers a substitution
    localparam int unsigned ZERO_RUN = 3;

    function automatic rails_t pulse_of(input logic positive);
        rails_t r;
        r.p = positive;
        r.n = ~positive;
        return r;
    endfunction

    function automatic sym_e sym_of_bit(input logic b);
        return b ? SYM_MARK : SYM_SPACE;
    endfunction

endpackage

// File: rtl/b3zs_window.sv
module b3zs_window
    import b3zs_pkg::*;
#(
    parameter int unsigned RUN_LEN = ZERO_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic sub_en,
    input  logic din,
    output sym_e sym_o,
    output logic trig_o
);
    localparam int unsigned NSTG = RUN_LEN - 1;

    sym_e [NSTG-1:0] stg_q;
    sym_e [NSTG-1:0] stg_d;
    logic            all_space;
    logic            trig;

    always_comb begin
        all_space = ~din;
        for (int k = 0; k < NSTG; k++) begin
            all_space = all_space & (stg_q[k] == SYM_SPACE);
        end
        trig = sub_en & all_space;
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stg_d[k] = trig ? SYM_VIOL : sym_of_bit(din);
        end else begin : g_body
            assign stg_d[k] = trig ? SYM_FILL : stg_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSTG; k++) begin
                stg_q[k] <= SYM_FILL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sym_o  = stg_q[NSTG-1];
    assign trig_o = trig;

endmodule

// File: rtl/b3zs_polarity.sv
module b3zs_polarity
    import b3zs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   unipolar,
    input  sym_e   sym_i,
    input  logic   trig_i,
    output rails_t rails_o
);
    logic   last_pos_q, last_pos_d;
    logic   odd_q, odd_d;
    rails_t rails_q, rails_d;

    always_comb begin
        last_pos_d = last_pos_q;
        odd_d      = odd_q;
        rails_d    = RAILS_IDLE;
        if (unipolar) begin
            rails_d.p = (sym_i == SYM_MARK);
        end else if (trig_i) begin
            // head of a substituted run: B only if count is even
            if (!odd_q) begin
                rails_d    = pulse_of(~last_pos_q);
                last_pos_d = ~last_pos_q;
                odd_d      = 1'b1;
            end
        end else begin
            unique case (sym_i)
                SYM_MARK: begin
                    rails_d    = pulse_of(~last_pos_q);
                    last_pos_d = ~last_pos_q;
                    odd_d      = ~odd_q;
                end
                SYM_VIOL: begin
                    rails_d = pulse_of(last_pos_q);
                    odd_d   = 1'b0;
                end
                default: rails_d = RAILS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
            rails_q    <= RAILS_IDLE;
        end else begin
            last_pos_q <= last_pos_d;
            odd_q      <= odd_d;
            rails_q    <= rails_d;
        end
    end

    assign rails_o = rails_q;

endmodule

// File: rtl/b3zs_edge_out.sv
module b3zs_edge_out
    import b3zs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fall_sel,
    input  rails_t rails_i,
    output rails_t rails_o
);
    rails_t fall_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= RAILS_IDLE;
        end else begin
            fall_q <= rails_i;
        end
    end

    assign rails_o = fall_sel ? fall_q : rails_i;

endmodule

// File: rtl/b3zs_line_enc.sv
module b3zs_line_enc
    import b3zs_pkg::*;
#(
    parameter int unsigned RUN_LEN = ZERO_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic code_ami,
    input  logic unipolar,
    input  logic fall_edge,
    output logic pos_o,
    output logic neg_o
);
    sym_e   win_sym;
    logic   win_trig;
    logic   sub_en;
    rails_t core_rails;
    rails_t line_rails;

    assign sub_en = ~code_ami & ~unipolar;

    b3zs_window #(.RUN_LEN(RUN_LEN)) u_window (
        .clk    (clk),
        .rst    (rst),
        .sub_en (sub_en),
        .din    (din),
        .sym_o  (win_sym),
        .trig_o (win_trig)
    );

    b3zs_polarity u_polarity (
        .clk      (clk),
        .rst      (rst),
        .unipolar (unipolar),
        .sym_i    (win_sym),
        .trig_i   (win_trig),
        .rails_o  (core_rails)
    );

    b3zs_edge_out u_edge (
        .clk      (clk),
        .rst      (rst),
        .fall_sel (fall_edge),
        .rails_i  (core_rails),
        .rails_o  (line_rails)
    );

    assign pos_o = line_rails.p;
    assign neg_o = line_rails.n;

endmodule

// File: rtl/b3zs_enc_chk.sv
module b3zs_enc_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic code_ami,
    input logic unipolar,
    input logic fall_edge,
    input logic pos_o,
    input logic neg_o
);
    logic       seen_pos;
    logic       alt_odd;
    logic [1:0] warm;
    logic       any_pulse;

    assign any_pulse = pos_o | neg_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_pos <= 1'b0;
            alt_odd  <= 1'b0;
            warm     <= 2'd0;
        end else begin
            if (warm != 2'd3) warm <= warm + 2'd1;
            if (any_pulse && !unipolar) begin
                if (pos_o == seen_pos) alt_odd <= 1'b0;
                else                   alt_odd <= ~alt_odd;
                seen_pos <= pos_o;
            end
        end
    end

    a_r9_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pos_o && neg_o));

    a_r1_ami_alternates: assert property (@(posedge clk) disable iff (rst)
        (code_ami && !unipolar && any_pulse) |-> (pos_o != seen_pos));

    a_r3_viol_after_odd: assert property (@(posedge clk) disable iff (rst)
        (!code_ami && !unipolar && any_pulse && (pos_o == seen_pos)) |-> alt_odd);

    a_r5_neg_quiet: assert property (@(posedge clk) disable iff (rst)
        unipolar |-> !neg_o);

    // R6 latency seen through the unipolar path
    a_r5_uni_follows: assert property (@(posedge clk) disable iff (rst)
        (unipolar && !fall_edge && warm == 2'd3) |-> (pos_o == $past(din, 3)));

endmodule

bind b3zs_line_enc b3zs_enc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .code_ami  (code_ami),
    .unipolar  (unipolar),
    .fall_edge (fall_edge),
    .pos_o     (pos_o),
    .neg_o     (neg_o)
);

// File: tb/sim_b3zs_line_enc.sv
`timescale 1ns/1ps
module sim_b3zs_line_enc;

    typedef struct {
        bit b;
        int idx;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic code_ami = 1'b0;
    logic unipolar = 1'b0;
    logic fall_edge = 1'b0;
    logic pos_o, neg_o;

    int    n_checks = 0;
    int    n_fail = 0;
    int    ecount = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R8";
    item_t q[$];

    // reference model state
    bit m_last = 1'b0;
    bit m_odd = 1'b0;
    int m_skip = 0;
    bit prev_p = 1'b0, prev_n = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    b3zs_line_enc u0 (
        .clk(clk), .rst(rst), .din(din), .code_ami(code_ami),
        .unipolar(unipolar), .fall_edge(fall_edge),
        .pos_o(pos_o), .neg_o(neg_o)
    );

    always @(posedge clk) ecount <= ecount + 1;

    task automatic chk(input string tag, input bit gp, input bit gn,
                       input bit ep, input bit en);
        n_checks++;
        if (gp !== ep || gn !== en) begin
            n_fail++;
            $display("FAIL %s: rails got p=%0b n=%0b expected p=%0b n=%0b (t=%0t)",
                     tag, gp, gn, ep, en, $time);
        end
    endtask

    // Reference: decide rails for window w0 (oldest), w1, w2
    task automatic model(input bit w0, input bit w1, input bit w2,
                         output bit ep, output bit en);
        bit sub;
        sub = !code_ami && !unipolar;
        ep = 1'b0; en = 1'b0;
        if (unipolar) begin
            ep = w0;
        end else if (m_skip == 2) begin
            m_skip = 1;
        end else if (m_skip == 1) begin
            ep = m_last; en = !m_last;      // V repeats polarity (R3)
            m_odd = 1'b0;
            m_skip = 0;
        end else if (sub && !w0 && !w1 && !w2) begin
            if (!m_odd) begin               // B0V (R2)
                ep = !m_last; en = m_last;
                m_last = !m_last;
                m_odd = 1'b1;
            end
            m_skip = 2;
        end else if (w0) begin
            ep = !m_last; en = m_last;
            m_last = !m_last;
            m_odd = !m_odd;
        end
    endtask

    // Monitor: pops the bit whose output is due and compares (R6/R7)
    always @(posedge clk) begin
        #2;
        if (mon_on && q.size() >= 3 && q[0].idx == ecount - 2) begin
            bit ep, en;
            model(q[0].b, q[1].b, q[2].b, ep, en);
            if (fall_edge) begin
                chk({cur_tag, " R7 hold"}, pos_o, neg_o, prev_p, prev_n);
                @(negedge clk);
                #1;
                chk({cur_tag, " R7 fall"}, pos_o, neg_o, ep, en);
            end else begin
                chk({cur_tag, " R6"}, pos_o, neg_o, ep, en);
            end
            n_checks++;
            if (pos_o && neg_o) begin
                n_fail++;
                $display("FAIL R9: rails got p=1 n=1 expected not both high");
            end
            prev_p = ep; prev_n = en;
            void'(q.pop_front());
        end
    end

    task automatic send_bit(input bit b);
        item_t it;
        din = b;
        it.b = b;
        it.idx = ecount + 1;
        q.push_back(it);
        @(posedge clk);
        #1;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1");
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit ami, input bit uni, input bit fe);
        mon_on = 1'b0;
        rst = 1'b1;
        code_ami = ami; unipolar = uni; fall_edge = fe;
        din = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset rails", pos_o, neg_o, 1'b0, 1'b0);
        q.delete();
        m_last = 1'b0; m_odd = 1'b0; m_skip = 0;
        prev_p = 1'b0; prev_n = 1'b0;
        rst = 1'b0;
        mon_on = 1'b1;
    endtask

    initial begin
        @(posedge clk);
        #1;
        // R1/R4: alternate mark, long space run stays empty, first pulse positive (R8)
        do_reset(1'b1, 1'b0, 1'b0);
        cur_tag = "R1 R4 ami";
        send_str("1011000000111010001");
        // R2/R3: substitution on a mixed stream
        do_reset(1'b0, 1'b0, 1'b0);
        cur_tag = "R2 R3 mixed";
        send_str("1011000101111011011001110001");
        // R2: odd count before run -> 00V; even -> B0V
        do_reset(1'b0, 1'b0, 1'b0);
        cur_tag = "R2 odd-00V";
        send_str("1000110001110000");
        // R2/R3: long space runs chaining substitutions from reset
        do_reset(1'b0, 1'b0, 1'b0);
        cur_tag = "R2 R3 long-run";
        send_str("000000000000100000001");
        // R5: unipolar ignores code select (both values)
        do_reset(1'b0, 1'b1, 1'b0);
        cur_tag = "R5 uni sel0";
        send_str("10000001101000");
        do_reset(1'b1, 1'b1, 1'b0);
        cur_tag = "R5 uni sel1";
        send_str("0110000001");
        // R7: falling-edge output timing with substitution
        do_reset(1'b0, 1'b0, 1'b1);
        cur_tag = "R7 R2 fall";
        send_str("1100010000001011");
        // R7: falling-edge with alternate mark
        do_reset(1'b1, 1'b0, 1'b1);
        cur_tag = "R7 R1 fall";
        send_str("1110100001");
        mon_on = 1'b0;
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule